// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs external memory and I/O transfers for a small 16-bit processor core. It accepts one request at a time from the core. It then steps the external bus through a fixed sequence of clock phases, adding stretch phases when the target is slow. During the sequence it drives two address paths together. A full 20-bit address `a` stays valid for the whole transfer. A shared address/data lane `ad` carries the low address bits only in the first phase and then carries data. The block also makes the strobes that asynchronous SRAMs expect: an address latch pulse, read and write strobes, a high-byte enable, and byte-lane write strobes built from those signals.

The parameter `WIDE` selects the data width. With `WIDE=1` the external data path is 16 bits and there are separate high and low byte-lane write strobes. With `WIDE=0` the path is 8 bits and one byte write strobe is used. In this mode a word request is carried out as two back-to-back byte transfers. The core holds `req` high for one clock while the sequencer is idle. It then waits for the one-clock `rsp_done` pulse, which comes with the read data on `rsp_rdata`.

The phases are named IDLE, T1, T2, T3, TW and T4. The transitions are: IDLE to T1 on a request; T1 to T2; T2 to T3; T3 to T4 when `ready` is high, or T3 to TW when it is low; TW to TW while `ready` stays low, and TW to T4 once it is high; T4 to T1 when a second byte of a split word remains; otherwise T4 to IDLE.

Top module: `mux_bus_seq`

## Requirements
- R1: After a request is accepted in IDLE, the bus passes through T1, T2, T3, then zero or more TW, then T4, one clock each. `ale` is high only in T1. `rd_n` (reads) or `wr_n` (writes) is low only in T2, T3 and TW.
- R2: Output `a` holds the transfer address unchanged from T1 through T4 and is zero in IDLE.
- R3: In T1, `ad_oe`=1 and `ad_out` equals `a[15:0]`. For reads, `ad_oe`=0 from T2 through T4. For writes, `ad_out` carries the write data from T2 through T4. In 16-bit mode a byte is written on both lanes; in 8-bit mode the byte is on `ad_out[7:0]` and bits 15:8 are zero.
- R4: In 16-bit mode, `bhe_n` is low from T1 through T4 for word transfers and for byte transfers to odd addresses. A word transfer puts its address on the bus with bit 0 cleared. In 8-bit mode `bhe_n` stays high.
- R5: In 16-bit mode, `whb_n` equals `bhe_n` OR `wr_n`, `wlb_n` equals `a[0]` OR `wr_n`, and `wb_n` stays high.
- R6: In 8-bit mode, `wb_n` follows `wr_n`, so it is low exactly while a byte is written on `ad[7:0]`. `whb_n` and `wlb_n` stay high.
- R7: In 8-bit mode, a word request runs as two full transfers, at address A and then A+1 (modulo 2^20), with the low byte first. `rsp_done` comes only after the second transfer.
- R8: `ready` is sampled only on the clock edge that ends T3 or TW. Low inserts a TW phase and high moves to T4. `ready` has no effect in any other phase.
- R9: Read data is taken from `ad_in` on the edge into T4. In 16-bit mode: a word gives `ad_in`; an odd byte gives {0, `ad_in[15:8]`}; an even byte gives {0, `ad_in[7:0]`}. In 8-bit mode: a byte gives {0, `ad_in[7:0]`}; a word gives {second byte, first byte}. The result is valid on `rsp_rdata` while `rsp_done` is high.
- R10: `rsp_done` is high for exactly one clock, during the final T4 of a request.
- R11: `io_sel` equals the request's space flag (1 = I/O, 0 = memory) from T1 through T4 and is 0 in IDLE.
- R12: In IDLE all strobes are inactive, `ale` is low and `ad_oe` is low. A request raised while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transfer request, sampled in IDLE |
| req_addr | input | 20 | Transfer byte address |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| rsp_rdata | output | 16 | Read data result |
| rsp_done | output | 1 | One-clock completion pulse |
| a | output | 20 | Non-multiplexed address |
| ad_out | output | 16 | Multiplexed address/data drive value |
| ad_oe | output | 1 | Drive enable for the ad lane |
| ad_in | input | 16 | Value received on the ad lane |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | High-byte enable, active low |
| whb_n | output | 1 | High-byte write strobe (16-bit mode) |
| wlb_n | output | 1 | Low-byte write strobe (16-bit mode) |
| wb_n | output | 1 | Byte write strobe (8-bit mode) |
| io_sel | output | 1 | Space of the current transfer |
| ready | input | 1 | Target ready, sampled at end of T3/TW |

## Verification
The bench targets four corner cases.

- **Odd byte address in 16-bit mode.** A design that misroutes it would assert the low-lane strobe or return the wrong byte of `ad_in`.
- **Word at an odd address in 16-bit mode.** Here bit 0 must be cleared on the bus. A design that skips this would strobe only the high lane.
- **Split word in 8-bit mode at the top of the address space.** The second half must wrap to address zero. A bad design would stop after one byte, swap the halves, or pulse `rsp_done` early.
- **Ready held low through T2 and lengthy stall sequences.** A design that samples `ready` in the wrong phase would lose or add a TW phase.

The bench also raises `req` in the middle of each transfer. A design that latched it would show an extra T1 where IDLE is expected.

// File: rtl/bus_pkg.sv
package bus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_TW,
        PH_T4
    } phase_t;

    // read-capture lane codes
    localparam logic [1:0] CAP_LO_TO_LO = 2'b00;
    localparam logic [1:0] CAP_HI_TO_LO = 2'b01;
    localparam logic [1:0] CAP_WORD     = 2'b10;
    localparam logic [1:0] CAP_LO_TO_HI = 2'b11;
endpackage

// File: rtl/bus_lane_gen.sv
module bus_lane_gen #(
    parameter bit WIDE = 1'b1
) (
    input  logic bhe_n,
    input  logic a0,
    input  logic wr_n,
    output logic whb_n,
    output logic wlb_n,
    output logic wb_n
);
    localparam logic LANES_OFF = !WIDE;

    // split strobes in 16-bit mode, single strobe in 8-bit mode
    assign whb_n = bhe_n | wr_n | LANES_OFF;
    assign wlb_n = a0 | wr_n | LANES_OFF;
    assign wb_n  = wr_n | !LANES_OFF;
endmodule

// File: rtl/bus_rd_cap.sv
module bus_rd_cap
    import bus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [1:0]    code,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] rdata
);
    localparam int BW = DW / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cap) begin
            unique case (code)
                CAP_LO_TO_LO: rdata <= {{BW{1'b0}}, ad_in[BW-1:0]};
                CAP_HI_TO_LO: rdata <= {{BW{1'b0}}, ad_in[DW-1:BW]};
                CAP_WORD:     rdata <= ad_in;
                CAP_LO_TO_HI: rdata <= {ad_in[BW-1:0], rdata[BW-1:0]};
            endcase
        end
    end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import bus_pkg::*;
#(
    parameter bit WIDE = 1'b1,
    parameter int AW   = 20,
    parameter int DW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW-1:0] req_addr,
    input  logic          req_io,
    input  logic          req_wr,
    input  logic          req_word,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic [AW-1:0] a,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_in,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          bhe_n,
    output logic          whb_n,
    output logic          wlb_n,
    output logic          wb_n,
    output logic          io_sel,
    input  logic          ready
);
    localparam int BW = DW / 2;

    phase_t        ph, ph_nx;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          io_q, wr_q, word_q, piece_q;

    logic [AW-1:0] cur_addr;
    logic [DW-1:0] wlane;
    logic [1:0]    cap_code;
    logic          active, data_ph, last_piece, cap;

    assign active     = (ph != PH_IDLE);
    assign data_ph    = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW);
    assign last_piece = WIDE || !word_q || piece_q;
    assign cap        = ((ph == PH_T3) || (ph == PH_TW)) && ready && !wr_q;

    generate
        if (WIDE) begin : g_wide
            assign cur_addr = word_q ? {addr_q[AW-1:1], 1'b0} : addr_q;
            assign wlane    = word_q ? wdata_q : {2{wdata_q[BW-1:0]}};
            assign cap_code = word_q ? CAP_WORD
                            : (cur_addr[0] ? CAP_HI_TO_LO : CAP_LO_TO_LO);
        end else begin : g_narrow
            assign cur_addr = addr_q + AW'(piece_q);
            assign wlane    = {{BW{1'b0}}, piece_q ? wdata_q[DW-1:BW] : wdata_q[BW-1:0]};
            assign cap_code = piece_q ? CAP_LO_TO_HI : CAP_LO_TO_LO;
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_IDLE;
        else        ph <= ph_nx;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            io_q    <= 1'b0;
            wr_q    <= 1'b0;
            word_q  <= 1'b0;
            piece_q <= 1'b0;
        end else if (ph == PH_IDLE && req) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            io_q    <= req_io;
            wr_q    <= req_wr;
            word_q  <= req_word;
            piece_q <= 1'b0;
        end else if (ph == PH_T4 && !last_piece) begin
            piece_q <= 1'b1;
        end
    end

    // next phase
    always_comb begin
        ph_nx = PH_IDLE;
        unique case (ph)
            PH_IDLE: ph_nx = req ? PH_T1 : PH_IDLE;
            PH_T1:   ph_nx = PH_T2;
            PH_T2:   ph_nx = PH_T3;
            PH_T3:   ph_nx = ready ? PH_T4 : PH_TW;
            PH_TW:   ph_nx = ready ? PH_T4 : PH_TW;
            PH_T4:   ph_nx = last_piece ? PH_IDLE : PH_T1;
        endcase
    end

    // phase outputs
    always_comb begin
        a        = active ? cur_addr : '0;
        ale      = (ph == PH_T1);
        ad_oe    = (ph == PH_T1) || (wr_q && (data_ph || ph == PH_T4));
        ad_out   = '0;
        if (ph == PH_T1)  ad_out = cur_addr[DW-1:0];
        else if (ad_oe)   ad_out = wlane;
        rd_n     = !(data_ph && !wr_q);
        wr_n     = !(data_ph && wr_q);
        bhe_n    = 1'b1;
        if (WIDE && active) bhe_n = !(word_q || cur_addr[0]);
        io_sel   = active && io_q;
        rsp_done = (ph == PH_T4) && last_piece;
    end

    bus_lane_gen #(.WIDE(WIDE)) u_lanes (
        .bhe_n (bhe_n),
        .a0    (cur_addr[0]),
        .wr_n  (wr_n),
        .whb_n (whb_n),
        .wlb_n (wlb_n),
        .wb_n  (wb_n)
    );

    bus_rd_cap #(.DW(DW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .code  (cap_code),
        .ad_in (ad_in),
        .rdata (rsp_rdata)
    );

    // R1: latch pulse is followed by an active strobe phase
    a_r1_ale_then_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && (!rd_n || !wr_n)));
    // R2: address path steady through a transfer
    a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_T1 || ph == PH_T2 || ph == PH_T3 || ph == PH_TW) |=> $stable(a));
    // R3: ad carries the address while ale is high
    a_r3_ale_addr_on_ad: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && ad_out == a[DW-1:0]));
    // R3: lane floats while the read strobe is active
    a_r3_read_float: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R5 / R6: no write lane strobe during a read
    a_r5_no_lane_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (whb_n && wlb_n && wb_n));
    // R8: not ready at the end of T3 gives a wait phase
    a_r8_wait_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_T3 && !ready) |=> (ph == PH_TW && !rd_n == !wr_q));
    // R10: completion pulse lasts one clock
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R12: idle bus is quiet
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_IDLE) |-> (rd_n && wr_n && !ale && !ad_oe && whb_n && wlb_n && wb_n));
endmodule

// File: tb/sim_mux_bus_seq.sv
module sim_mux_bus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, m8 = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_io = 1'b0, req_wr = 1'b0, req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [15:0] ad_in = '0;
    logic        ready = 1'b1;
    int          nchk = 0, nerr = 0;

    always #10 clk = ~clk;

    logic [15:0] rd0, rd1, ado0, ado1;
    logic [19:0] a0, a1;
    logic dn0, dn1, oe0, oe1, al0, al1, rn0, rn1, wn0, wn1, bh0, bh1;
    logic hb0, hb1, lb0, lb1, wb0, wb1, io0, io1;

    mux_bus_seq #(.WIDE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req && !m8), .req_addr(req_addr), .req_io(req_io),
        .req_wr(req_wr), .req_word(req_word), .req_wdata(req_wdata), .rsp_rdata(rd0),
        .rsp_done(dn0), .a(a0), .ad_out(ado0), .ad_oe(oe0), .ad_in(ad_in), .ale(al0),
        .rd_n(rn0), .wr_n(wn0), .bhe_n(bh0), .whb_n(hb0), .wlb_n(lb0), .wb_n(wb0),
        .io_sel(io0), .ready(ready));

    mux_bus_seq #(.WIDE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req(req && m8), .req_addr(req_addr), .req_io(req_io),
        .req_wr(req_wr), .req_word(req_word), .req_wdata(req_wdata), .rsp_rdata(rd1),
        .rsp_done(dn1), .a(a1), .ad_out(ado1), .ad_oe(oe1), .ad_in(ad_in), .ale(al1),
        .rd_n(rn1), .wr_n(wn1), .bhe_n(bh1), .whb_n(hb1), .wlb_n(lb1), .wb_n(wb1),
        .io_sel(io1), .ready(ready));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare one clock of the selected instance against the model
    task automatic cyc(input string ph, input logic [19:0] ea, input bit eale, input bit eoe,
                       input bit cko, input logic [15:0] ead, input bit erd, input bit ewr,
                       input bit ebhe, input bit ewhb, input bit ewlb, input bit ewb,
                       input bit eio, input bit edone);
        string lt = m8 ? "R6" : "R5";
        chk({"R2 a ", ph},       m8 ? a1 : a0, ea);
        chk({"R1 ale ", ph},     m8 ? al1 : al0, eale);
        chk({"R3 ad_oe ", ph},   m8 ? oe1 : oe0, eoe);
        if (cko) chk({"R3 ad_out ", ph}, m8 ? ado1 : ado0, ead);
        chk({"R1 rd_n ", ph},    m8 ? rn1 : rn0, erd);
        chk({"R1 wr_n ", ph},    m8 ? wn1 : wn0, ewr);
        chk({"R4 bhe_n ", ph},   m8 ? bh1 : bh0, ebhe);
        chk({lt, " whb_n ", ph}, m8 ? hb1 : hb0, ewhb);
        chk({lt, " wlb_n ", ph}, m8 ? lb1 : lb0, ewlb);
        chk({lt, " wb_n ", ph},  m8 ? wb1 : wb0, ewb);
        chk({"R11 io_sel ", ph}, m8 ? io1 : io0, eio);
        chk({"R10 done ", ph},   m8 ? dn1 : dn0, edone);
    endtask

    task automatic xfer(input bit mode8, input logic [19:0] addr, input bit io, input bit wr,
                        input bit word, input logic [15:0] wd, input logic [15:0] b0,
                        input logic [15:0] b1, input int waits);
        int np = (mode8 && word) ? 2 : 1;
        logic [15:0] erd;
        @(negedge clk);
        m8 = mode8; req = 1'b1; req_addr = addr; req_io = io; req_wr = wr;
        req_word = word; req_wdata = wd; ready = 1'b1;
        @(negedge clk);
        req = 1'b0; ready = 1'b0;
        for (int p = 0; p < np; p++) begin
            logic [19:0] ea;
            logic [15:0] ed, bus;
            bit ebhe, ewn;
            ea   = mode8 ? addr + 20'(p) : (word ? {addr[19:1], 1'b0} : addr);
            ebhe = mode8 ? 1'b1 : !(word || ea[0]);
            ed   = mode8 ? {8'h00, (p == 1) ? wd[15:8] : wd[7:0]}
                         : (word ? wd : {wd[7:0], wd[7:0]});
            bus  = (p == 1) ? b1 : b0;
            ewn  = !wr;
            // T1
            cyc("T1", ea, 1, 1, 1, ea[15:0], 1, 1, ebhe, 1, 1, 1, io, 0);
            @(negedge clk);
            // R12: request raised mid-transfer must be ignored
            req = 1'b1; req_addr = ~addr;
            // R8: ready low in T2 is ignored
            cyc("T2", ea, 0, wr, wr, ed, wr, ewn, ebhe, mode8 ? 1'b1 : (ebhe | ewn),
                mode8 ? 1'b1 : (ea[0] | ewn), mode8 ? ewn : 1'b1, io, 0);
            @(negedge clk);
            req = 1'b0;
            cyc("T3 R8", ea, 0, wr, wr, ed, wr, ewn, ebhe, mode8 ? 1'b1 : (ebhe | ewn),
                mode8 ? 1'b1 : (ea[0] | ewn), mode8 ? ewn : 1'b1, io, 0);
            ready = (waits == 0); ad_in = bus;
            for (int w = 0; w < waits; w++) begin
                @(negedge clk);
                cyc("TW R8", ea, 0, wr, wr, ed, wr, ewn, ebhe, mode8 ? 1'b1 : (ebhe | ewn),
                    mode8 ? 1'b1 : (ea[0] | ewn), mode8 ? ewn : 1'b1, io, 0);
                ready = (w == waits - 1);
            end
            @(negedge clk);
            cyc("T4", ea, 0, wr, wr, ed, 1, 1, ebhe, 1, 1, 1, io, p == np - 1);
            if (!wr && p == np - 1) begin
                if (!mode8) erd = word ? b0 : (ea[0] ? {8'h00, b0[15:8]} : {8'h00, b0[7:0]});
                else        erd = word ? {b1[7:0], b0[7:0]} : {8'h00, b0[7:0]};
                chk(mode8 && word ? "R7 R9 rdata split" : "R9 rdata", m8 ? rd1 : rd0, erd);
            end
            ready = 1'b0;
            @(negedge clk);
        end
        cyc("IDLE R12", 20'h0, 0, 0, 1, 16'h0, 1, 1, 1, 1, 1, 1, 0, 0);
        ready = 1'b1;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        m8 = 1'b0;
        cyc("RESET R12", 20'h0, 0, 0, 1, 16'h0, 1, 1, 1, 1, 1, 1, 0, 0);
        m8 = 1'b1;
        cyc("RESET R12", 20'h0, 0, 0, 1, 16'h0, 1, 1, 1, 1, 1, 1, 0, 0);
        rst_n = 1'b1;
        // 16-bit mode
        xfer(0, 20'h12344, 0, 1, 1, 16'hC0DE, 0, 0, 0);        // word write
        xfer(0, 20'hABCDF, 1, 1, 0, 16'h0077, 0, 0, 2);        // odd byte write, waits
        xfer(0, 20'h00A10, 0, 1, 0, 16'h00E3, 0, 0, 1);        // even byte write
        xfer(0, 20'h00101, 0, 0, 1, 0, 16'hBEEF, 0, 1);        // word read, odd addr
        xfer(0, 20'h40003, 0, 0, 0, 0, 16'h5AA5, 0, 0);        // odd byte read
        xfer(0, 20'h40002, 1, 0, 0, 0, 16'h5AA5, 0, 3);        // even byte read, io
        // 8-bit mode
        xfer(1, 20'h00050, 1, 1, 0, 16'h0091, 0, 0, 0);        // byte write
        xfer(1, 20'hFFFFF, 0, 1, 1, 16'hA1B2, 0, 0, 1);        // R7 split word write, wrap
        xfer(1, 20'h20000, 0, 0, 1, 0, 16'h1234, 16'hAB56, 2); // R7 split word read
        xfer(1, 20'h20007, 1, 0, 0, 0, 16'hFF3C, 0, 4);        // byte read
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule